// File: doc/BRIEF.md
# RS485 Transmit Direction Controller

This block drives the direction of a half-duplex RS485 transceiver. The transceiver's driver-enable line is wired to the UART RTS pin. When the UART has data to send, the block moves RTS to a configured "sending" level. It can then wait a programmable number of bit times before it lets the transmitter release its first start bit.

Once the transmit FIFO has drained and the last stop bit has left the shifter, the block can wait a second programmable number of bit times. It then returns RTS to a separately configured "after-send" level. While the line is driven, the UART receiver can be held off so that the node does not read back its own echo. A fresh request that arrives during the trailing delay goes straight back to sending, and the driver is not released in between.

When the direction mode is switched off, RTS is handed to the ordinary automatic flow-control level. The two sources therefore never drive the pin together.

Top module: `rs485_dir_ctrl`

## Requirements
- R1: With the mode enabled and no request pending (including straight after reset), `rts_out` equals `cfg_rts_after`, `rx_en` is 1 and `tx_go` is 0.
- R2: A request (`tx_req` high) seen at a clock edge while idle moves `rts_out` to `cfg_rts_send` from the next cycle on.
- R3: With a pre-delay of N (0..15), `tx_go` rises exactly on the edge that carries the N-th `bit_tick` after the request is accepted. With N = 0, `tx_go` rises on the cycle right after the request.
- R4: Sending ends only at an edge where `tx_idle` is 1 and `tx_req` is 0. Until then `tx_go` stays 1 and `rts_out` keeps the send level.
- R5: With a post-delay of M (0..15), `rts_out` returns to `cfg_rts_after` and `rx_en` returns to 1 on the edge that carries the M-th `bit_tick` after sending ends. With M = 0 this happens at once.
- R6: Both delays advance only on `bit_tick`. Clock cycles without a tick do not shorten them.
- R7: A request during the post-delay returns the block to sending on the next cycle: `tx_go` becomes 1 and `rts_out` does not change. A later post-delay starts again from its full count.
- R8: With `mode_en` at 0, `rts_out` follows `flow_rts`, `rx_en` is 1 and `tx_go` is 1, and requests have no effect.
- R9: From the request until the end of the post-delay, `rx_en` equals `cfg_rx_during_tx`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_en | input | 1 | Enables RS485 direction control; when 0, RTS belongs to flow control |
| flow_rts | input | 1 | RTS level from automatic flow control |
| tx_req | input | 1 | High while the transmit FIFO holds data |
| tx_idle | input | 1 | High when the FIFO is empty and the last stop bit is shifted out |
| bit_tick | input | 1 | One-cycle pulse per bit time |
| cfg_rts_send | input | 1 | RTS level while driving |
| cfg_rts_after | input | 1 | RTS level when not driving |
| cfg_rx_during_tx | input | 1 | 1 keeps the receiver on while driving |
| cfg_pre_dly | input | DLY_W | Bit times between the send level and the first start bit |
| cfg_post_dly | input | DLY_W | Bit times between the last stop bit and the after-send level |
| tx_go | output | 1 | Permits the transmitter to start shifting |
| rts_out | output | 1 | RTS / driver-enable pin level |
| rx_en | output | 1 | UART receiver enable |

## Verification
The assertions assume that `bit_tick` is a single-cycle pulse. They also assume that `tx_idle` is never 1 while `tx_req` still reports queued data, except in the way a real FIFO and shifter would produce. The stimulus follows this. It drops `tx_req` before it raises `tx_idle`, and it raises `tx_req` again only with `tx_idle` cleared. Configuration bits are changed only while the block is idle. Every send, after-send and receive-during-transmit combination is swept against a spread of delay values.

// File: rtl/rs485_dir_pkg.sv
package rs485_dir_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_PRE  = 2'd1,
        ST_SEND = 2'd2,
        ST_POST = 2'd3
    } dir_state_e;

    typedef struct packed {
        logic rts_send;
        logic rts_after;
        logic rx_during_tx;
    } dir_cfg_t;

    typedef struct packed {
        logic rts;
        logic rx_en;
        logic go;
    } dir_out_t;

    function automatic dir_out_t drive_for(dir_state_e st, dir_cfg_t cfg);
        dir_out_t o;
        o.rts   = (st == ST_IDLE) ? cfg.rts_after : cfg.rts_send;
        o.rx_en = (st == ST_IDLE) ? 1'b1 : cfg.rx_during_tx;
        o.go    = (st == ST_SEND);
        return o;
    endfunction

endpackage

// File: rtl/rs485_bit_delay.sv
module rs485_bit_delay #(
    parameter int DLY_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [DLY_W-1:0] load_val,
    input  logic             tick,
    output logic             expired
);
    localparam logic [DLY_W-1:0] ONE = DLY_W'(1);

    logic [DLY_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= load_val;
        end else if (tick && cnt != '0) begin
            cnt <= cnt - ONE;
        end
    end

    assign expired = tick && (cnt == ONE);

    AST_CNT_HOLDS_NO_TICK: assert property (@(posedge clk) disable iff (rst)
        (!load && !tick) |=> $stable(cnt)); // R6

endmodule

// File: rtl/rs485_dir_fsm.sv
module rs485_dir_fsm
    import rs485_dir_pkg::*;
#(
    parameter int DLY_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             mode_en,
    input  logic             tx_req,
    input  logic             tx_idle,
    input  logic             dly_expired,
    input  logic [DLY_W-1:0] pre_dly,
    input  logic [DLY_W-1:0] post_dly,
    input  dir_cfg_t         cfg,
    output logic             dly_load,
    output logic [DLY_W-1:0] dly_val,
    output dir_out_t         drv
);
    dir_state_e st, st_nx;

    always_comb begin
        st_nx    = st;
        dly_load = 1'b0;
        dly_val  = pre_dly;
        unique case (st)
            ST_IDLE: if (tx_req) begin
                dly_load = 1'b1;
                st_nx    = (pre_dly == '0) ? ST_SEND : ST_PRE;
            end
            ST_PRE: if (dly_expired) st_nx = ST_SEND;
            ST_SEND: if (tx_idle && !tx_req) begin
                dly_load = 1'b1;
                dly_val  = post_dly;
                st_nx    = (post_dly == '0) ? ST_IDLE : ST_POST;
            end
            ST_POST: begin
                if (tx_req)           st_nx = ST_SEND;
                else if (dly_expired) st_nx = ST_IDLE;
            end
            default: st_nx = ST_IDLE;
        endcase
        if (!mode_en) st_nx = ST_IDLE;
    end

    always_ff @(posedge clk) begin
        if (rst) st <= ST_IDLE;
        else     st <= st_nx;
    end

    assign drv = drive_for(st, cfg);

    AST_RETRIGGER_NO_TOGGLE: assert property (@(posedge clk) disable iff (rst)
        (mode_en && st == ST_POST && tx_req) |=> (drv.go && $stable(drv.rts))); // R7

    AST_END_NEEDS_IDLE: assert property (@(posedge clk) disable iff (rst)
        (mode_en && st == ST_SEND && !(tx_idle && !tx_req)) |=> drv.go); // R4

    AST_IDLE_STAYS_QUIET: assert property (@(posedge clk) disable iff (rst)
        (st == ST_IDLE && !tx_req) |=> !drv.go); // R1

    AST_PRE_WAITS_TICK: assert property (@(posedge clk) disable iff (rst)
        (mode_en && st == ST_PRE && !dly_expired) |=> !drv.go); // R3

endmodule

// File: rtl/rs485_dir_ctrl.sv
module rs485_dir_ctrl
    import rs485_dir_pkg::*;
#(
    parameter int DLY_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             mode_en,
    input  logic             flow_rts,
    input  logic             tx_req,
    input  logic             tx_idle,
    input  logic             bit_tick,
    input  logic             cfg_rts_send,
    input  logic             cfg_rts_after,
    input  logic             cfg_rx_during_tx,
    input  logic [DLY_W-1:0] cfg_pre_dly,
    input  logic [DLY_W-1:0] cfg_post_dly,
    output logic             tx_go,
    output logic             rts_out,
    output logic             rx_en
);
    dir_cfg_t         cfg;
    dir_out_t         drv;
    logic             dly_load;
    logic [DLY_W-1:0] dly_val;
    logic             dly_expired;

    assign cfg = '{rts_send: cfg_rts_send, rts_after: cfg_rts_after,
                   rx_during_tx: cfg_rx_during_tx};

    rs485_dir_fsm #(.DLY_W(DLY_W)) u_fsm (
        .clk        (clk),
        .rst        (rst),
        .mode_en    (mode_en),
        .tx_req     (tx_req),
        .tx_idle    (tx_idle),
        .dly_expired(dly_expired),
        .pre_dly    (cfg_pre_dly),
        .post_dly   (cfg_post_dly),
        .cfg        (cfg),
        .dly_load   (dly_load),
        .dly_val    (dly_val),
        .drv        (drv)
    );

    rs485_bit_delay #(.DLY_W(DLY_W)) u_dly (
        .clk     (clk),
        .rst     (rst),
        .load    (dly_load),
        .load_val(dly_val),
        .tick    (bit_tick),
        .expired (dly_expired)
    );

    assign rts_out = mode_en ? drv.rts   : flow_rts;
    assign rx_en   = mode_en ? drv.rx_en : 1'b1;
    assign tx_go   = mode_en ? drv.go    : 1'b1;

    AST_RTS_FROM_ONE_SOURCE: assert property (@(posedge clk) disable iff (rst)
        mode_en |-> (rts_out == cfg_rts_send || rts_out == cfg_rts_after)); // R8

    AST_RX_ON_WHEN_QUIET: assert property (@(posedge clk) disable iff (rst)
        !tx_go |-> rx_en || !cfg_rx_during_tx == !rx_en); // R9

endmodule

// File: tb/rs485_dir_ctrl_tb.sv
module rs485_dir_ctrl_tb;
    localparam int CLK_PERIOD = 10;
    localparam int DLY_W = 4;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic mode_en = 1'b1, flow_rts = 1'b0, tx_req = 1'b0, tx_idle = 1'b1, bit_tick = 1'b0;
    logic cfg_rts_send = 1'b1, cfg_rts_after = 1'b0, cfg_rx_during_tx = 1'b0;
    logic [DLY_W-1:0] cfg_pre_dly = '0, cfg_post_dly = '0;
    logic tx_go, rts_out, rx_en;

    int n_checks = 0;
    int n_errors = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    rs485_dir_ctrl #(.DLY_W(DLY_W)) u_dut (
        .clk(clk), .rst(rst), .mode_en(mode_en), .flow_rts(flow_rts),
        .tx_req(tx_req), .tx_idle(tx_idle), .bit_tick(bit_tick),
        .cfg_rts_send(cfg_rts_send), .cfg_rts_after(cfg_rts_after),
        .cfg_rx_during_tx(cfg_rx_during_tx), .cfg_pre_dly(cfg_pre_dly),
        .cfg_post_dly(cfg_post_dly), .tx_go(tx_go), .rts_out(rts_out), .rx_en(rx_en)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic step(input logic tk);
        bit_tick = tk;
        @(posedge clk);
        #1;
        bit_tick = 1'b0;
    endtask

    // Counts ticks until tx_go rises; ticks fall on every third cycle.
    task automatic wait_go(output int ticks);
        int guard = 0;
        ticks = 0;
        while (!tx_go && guard < 200) begin
            logic tk = (guard % 3 == 2);
            step(tk);
            if (tk) ticks++;
            guard++;
        end
    endtask

    task automatic wait_after(output int ticks);
        int guard = 0;
        ticks = 0;
        while (rts_out != cfg_rts_after && guard < 200) begin
            logic tk = (guard % 3 == 2);
            step(tk);
            if (tk) ticks++;
            guard++;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            n_errors++;
            n_checks++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

    initial begin
        int t;
        logic [DLY_W-1:0] dly_set [4] = '{4'd0, 4'd1, 4'd5, 4'd15};
        step(1'b0);
        step(1'b0);
        rst = 1'b0;
        step(1'b0);
        // R1: reset state
        chk(rts_out == 1'b0 && rx_en && !tx_go, "R1", {rts_out, rx_en, tx_go}, 3'b010);

        // Sweep every level combination against several delay pairs
        for (int c = 0; c < 8; c++) begin
            for (int p = 0; p < 4; p++) begin
                for (int q = 0; q < 4; q++) begin
                    cfg_rts_send     = c[0];
                    cfg_rts_after    = c[1];
                    cfg_rx_during_tx = c[2];
                    cfg_pre_dly      = dly_set[p];
                    cfg_post_dly     = dly_set[(p + q) % 4];
                    step(1'b0);
                    chk(rts_out == cfg_rts_after && rx_en && !tx_go, "R1",
                        {rts_out, rx_en, tx_go}, {cfg_rts_after, 2'b10});
                    tx_req = 1'b1;
                    tx_idle = 1'b0;
                    step(1'b0);
                    chk(rts_out == cfg_rts_send, "R2", rts_out, cfg_rts_send);
                    chk(rx_en == cfg_rx_during_tx, "R9", rx_en, cfg_rx_during_tx);
                    wait_go(t);
                    chk(t == int'(cfg_pre_dly), "R3", t, cfg_pre_dly);
                    // FIFO drained but shifter busy: must keep sending
                    tx_req = 1'b0;
                    step(1'b1);
                    step(1'b1);
                    chk(tx_go && rts_out == cfg_rts_send, "R4",
                        {tx_go, rts_out}, {1'b1, cfg_rts_send});
                    tx_idle = 1'b1;
                    step(1'b0);
                    chk(!tx_go, "R4", tx_go, 0);
                    if (cfg_post_dly == '0) begin
                        chk(rts_out == cfg_rts_after && rx_en, "R5",
                            {rts_out, rx_en}, {cfg_rts_after, 1'b1});
                    end else begin
                        chk(rx_en == cfg_rx_during_tx, "R9", rx_en, cfg_rx_during_tx);
                        if (cfg_rts_send != cfg_rts_after) begin
                            wait_after(t);
                            chk(t == int'(cfg_post_dly), "R5", t, cfg_post_dly);
                        end else begin
                            for (int k = 0; k < int'(cfg_post_dly); k++) step(1'b1);
                        end
                        chk(rx_en && !tx_go, "R5", {rx_en, tx_go}, 2'b10);
                    end
                end
            end
        end

        // R6: no ticks means no progress through the pre-delay
        cfg_rts_send = 1'b1; cfg_rts_after = 1'b0; cfg_rx_during_tx = 1'b0;
        cfg_pre_dly = 4'd2; cfg_post_dly = 4'd3;
        step(1'b0);
        tx_req = 1'b1; tx_idle = 1'b0;
        step(1'b0);
        for (int k = 0; k < 12; k++) step(1'b0);
        chk(!tx_go, "R6", tx_go, 0);
        step(1'b1);
        chk(!tx_go, "R6", tx_go, 0);
        step(1'b1);
        chk(tx_go, "R6", tx_go, 1);

        // R7: retrigger in post-delay
        tx_req = 1'b0; tx_idle = 1'b1;
        step(1'b0);
        chk(rts_out == 1'b1 && !tx_go, "R7", {rts_out, tx_go}, 2'b10);
        step(1'b1);
        step(1'b1);
        chk(rts_out == 1'b1, "R7", rts_out, 1);
        tx_req = 1'b1; tx_idle = 1'b0;
        step(1'b0);
        chk(tx_go && rts_out == 1'b1, "R7", {tx_go, rts_out}, 2'b11);
        tx_req = 1'b0; tx_idle = 1'b1;
        step(1'b0);
        wait_after(t);
        chk(t == 3, "R7", t, 3);

        // R8: mode off gives RTS to flow control, requests ignored
        mode_en = 1'b0;
        for (int k = 0; k < 4; k++) begin
            flow_rts = k[0];
            tx_req = k[1];
            tx_idle = !k[1];
            step(1'b1);
            chk(rts_out == flow_rts && rx_en && tx_go, "R8",
                {rts_out, rx_en, tx_go}, {flow_rts, 2'b11});
        end
        tx_req = 1'b0; tx_idle = 1'b1;
        mode_en = 1'b1;
        step(1'b0);
        chk(rts_out == 1'b0 && rx_en && !tx_go, "R8", {rts_out, rx_en, tx_go}, 3'b010);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule